// File: doc/BRIEF.md
# Accumulating Nibble ALU with Carry and All-Ones Flags

This block is the arithmetic heart of a small nibble-serial processor. Each operation takes one fresh 4-bit operand from memory. The second operand is always the result of the operation before it, which the block keeps in its own accumulator register. The instruction sequencer presents a 3-bit function code and the memory nibble, then pulses a load strobe. On that clock edge the accumulator takes the new result, and two flags are captured with it: a carry and an all-ones indicator.

The all-ones flag is not a true comparator. It reports only that every result bit is 1. To test whether a memory nibble equals the accumulator, the program issues an XNOR and then branches on the flag. The carry is meaningful after an add, and after a decrement, where it reads 1 when no borrow occurred. Every logic function clears it.

A left shift costs two instructions: a move of the nibble, then an add of the same nibble. The add doubles the value and the bit shifted out lands in the carry.

Top module: `nib_acc_alu`

## Requirements
- R1: While reset is asserted and after its release, before any load, the result and both flags read 0.
- R2: Function code 000 (add) loads (A + accumulator) mod 16 and sets the carry to the fifth bit of the sum.
- R3: Function code 001 (XNOR) loads the bitwise XNOR of A and the accumulator. The all-ones flag is then 1 exactly when A equalled the old accumulator.
- R4: Function code 010 (pass last) leaves the accumulator value unchanged and clears the carry.
- R5: Function codes 011 (AND), 101 (NOT A OR accumulator) and 110 (OR) load the bitwise result and clear the carry.
- R6: Function code 100 (decrement) loads (A − 1) mod 16 and sets the carry exactly when A was not 0.
- R7: Function code 111 (move) loads A and clears the carry.
- R8: After every load, the all-ones flag is 1 exactly when all four result bits are 1.
- R9: In a cycle with the load strobe low, the result and both flags keep their values whatever the function code and A are.
- R10: A move of nibble N followed by an add of N gives (N shifted left by one) mod 16, with the carry equal to bit 3 of N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_i | input | 1 | Load strobe: perform the function and capture the result and flags |
| fn_i | input | 3 | Function code |
| opa_i | input | 4 | Operand nibble from memory |
| res_o | output | 4 | Accumulator (last result) |
| cy_o | output | 1 | Stored carry flag |
| ones_o | output | 1 | Stored all-ones flag |

## Verification
Every output is a register, so the effect of a strobe shows on the first rising edge that sees the strobe high. Reset release takes two extra edges, because the reset passes through the internal synchronizer. The bench drives its inputs on the falling edge and samples the outputs on the next falling edge. It holds a reference accumulator and updates it only on strobed cycles, so each check compares against a value due exactly one edge after its stimulus. Cycles with the strobe low are checked the same way against the unchanged reference.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  typedef enum logic [2:0] {
    FN_ADD   = 3'b000,
    FN_XNOR  = 3'b001,
    FN_LAST  = 3'b010,
    FN_AND   = 3'b011,
    FN_DEC   = 3'b100,
    FN_ORNOT = 3'b101,
    FN_OR    = 3'b110,
    FN_MOVE  = 3'b111
  } nib_fn_e;
endpackage

// File: rtl/nib_alu_core.sv
module nib_alu_core
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [2:0]   fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] f_o,
  output logic         c_o
);
  logic [W:0] sum_w;

  always_comb begin
    sum_w = {1'b0, a_i} + {1'b0, last_i};
    f_o   = a_i;
    c_o   = 1'b0;
    case (nib_fn_e'(fn_i))
      FN_ADD:   begin f_o = sum_w[W-1:0]; c_o = sum_w[W]; end
      FN_XNOR:  f_o = ~(a_i ^ last_i);
      FN_LAST:  f_o = last_i;
      FN_AND:   f_o = a_i & last_i;
      FN_DEC:   begin f_o = a_i - W'(1); c_o = |a_i; end
      FN_ORNOT: f_o = ~a_i | last_i;
      FN_OR:    f_o = a_i | last_i;
      FN_MOVE:  f_o = a_i;
      default:  f_o = a_i;
    endcase
  end
endmodule

// File: rtl/nib_alu_regs.sv
module nib_alu_regs #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] f_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ones_o
);
  logic [W-1:0] res_q, res_d;
  logic         cy_q, cy_d, ones_q, ones_d;

  always_comb begin
    res_d  = res_q;
    cy_d   = cy_q;
    ones_d = ones_q;
    if (ld_i) begin
      res_d  = f_i;
      cy_d   = c_i;
      ones_d = &f_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      cy_q   <= 1'b0;
      ones_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      cy_q   <= cy_d;
      ones_q <= ones_d;
    end
  end

  assign res_o  = res_q;
  assign cy_o   = cy_q;
  assign ones_o = ones_q;

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> ($stable(res_q) && $stable(cy_q) && $stable(ones_q))); // R9
  AST_ONES_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> (ones_q == (res_q == {W{1'b1}}))); // R8
endmodule

// File: rtl/nib_acc_alu.sv
module nib_acc_alu
  import nib_alu_pkg::*;
#(
  parameter int W        = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [2:0]   fn_i,
  input  logic [W-1:0] opa_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ones_o
);
  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_int_n;
  logic [W-1:0]        f_w;
  logic                c_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_LEN-1];

  nib_alu_core #(.W(W)) u_core (
    .fn_i   (fn_i),
    .a_i    (opa_i),
    .last_i (res_o),
    .f_o    (f_w),
    .c_o    (c_w)
  );

  nib_alu_regs #(.W(W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .ld_i   (ld_i),
    .f_i    (f_w),
    .c_i    (c_w),
    .res_o  (res_o),
    .cy_o   (cy_o),
    .ones_o (ones_o)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_int_n |-> (res_o == '0 && !cy_o && !ones_o)); // R1
  AST_MOVE_TAKES_A: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ld_i && fn_i == FN_MOVE) |=> (res_o == $past(opa_i) && !cy_o)); // R7
  AST_PASS_KEEPS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ld_i && fn_i == FN_LAST) |=> ($stable(res_o) && !cy_o)); // R4
  AST_DEC_CARRY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ld_i && fn_i == FN_DEC) |=> (cy_o == ($past(opa_i) != '0))); // R6
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ld_i && (fn_i == FN_AND || fn_i == FN_OR || fn_i == FN_ORNOT)) |=> !cy_o); // R5
  AST_XNOR_EQUAL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ld_i && fn_i == FN_XNOR) |=> (ones_o == ($past(opa_i) == $past(res_o)))); // R3
endmodule

// File: tb/nib_acc_alu_bench.sv
module nib_acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_i;
  logic [2:0] fn_i;
  logic [3:0] opa_i;
  logic [3:0] res_o;
  logic       cy_o, ones_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] m_res;
  logic       m_cy, m_ones;

  always #2 clk = ~clk;

  nib_acc_alu u_nib_acc_alu (
    .clk(clk), .rst_n(rst_n), .ld_i(ld_i), .fn_i(fn_i),
    .opa_i(opa_i), .res_o(res_o), .cy_o(cy_o), .ones_o(ones_o)
  );

  function automatic logic [4:0] ref_op(input logic [2:0] fn, input logic [3:0] a,
                                        input logic [3:0] l);
    logic [4:0] s;
    case (fn)
      3'b000: s = {1'b0, a} + {1'b0, l};
      3'b001: s = {1'b0, ~(a ^ l)};
      3'b010: s = {1'b0, l};
      3'b011: s = {1'b0, a & l};
      3'b100: s = {(a != 4'd0), a - 4'd1};
      3'b101: s = {1'b0, ~a | l};
      3'b110: s = {1'b0, a | l};
      default: s = {1'b0, a};
    endcase
    return s;
  endfunction

  function automatic string tag_of(input logic [2:0] fn);
    case (fn)
      3'b000: return "R2";
      3'b001: return "R3";
      3'b010: return "R4";
      3'b100: return "R6";
      3'b111: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag);
    n_chk++;
    if (res_o !== m_res || cy_o !== m_cy || ones_o !== m_ones) begin
      n_bad++;
      $display("FAIL %s: res=%h cy=%b ones=%b expected res=%h cy=%b ones=%b",
               tag, res_o, cy_o, ones_o, m_res, m_cy, m_ones);
    end
  endtask

  task automatic do_op(input logic [2:0] fn, input logic [3:0] a, input string tag);
    logic [4:0] s;
    @(negedge clk);
    ld_i = 1'b1; fn_i = fn; opa_i = a;
    s = ref_op(fn, a, m_res);
    @(negedge clk);
    ld_i = 1'b0;
    m_res = s[3:0]; m_cy = s[4]; m_ones = &s[3:0];
    check(tag);
    n_chk++;
    if (ones_o !== (res_o == 4'hF)) begin
      n_bad++;
      $display("FAIL R8: ones=%b expected %b", ones_o, (res_o == 4'hF));
    end
  endtask

  task automatic idle_cycle(input logic [2:0] fn, input logic [3:0] a);
    @(negedge clk);
    ld_i = 1'b0; fn_i = fn; opa_i = a;
    @(negedge clk);
    check("R9");
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_res = 4'h0; m_cy = 1'b0; m_ones = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1");
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] n;
    logic [4:0] sh;
    void'($urandom(32'h4E1B_0A1C));
    ld_i = 1'b0; fn_i = 3'b000; opa_i = 4'h0;
    do_reset();

    // R7 then R2 / R10: shift left by self add
    do_op(3'b111, 4'h9, "R7");
    do_op(3'b000, 4'h9, "R10");
    if (res_o !== 4'h2 || cy_o !== 1'b1) begin
      n_bad++; $display("FAIL R10: res=%h cy=%b expected res=2 cy=1", res_o, cy_o);
    end
    n_chk++;
    for (int i = 0; i < 16; i++) begin
      n = 4'(i);
      sh = {1'b0, n} << 1;
      do_op(3'b111, n, "R7");
      do_op(3'b000, n, "R10");
      n_chk++;
      if (res_o !== sh[3:0] || cy_o !== n[3]) begin
        n_bad++;
        $display("FAIL R10: res=%h cy=%b expected res=%h cy=%b", res_o, cy_o, sh[3:0], n[3]);
      end
    end

    // R2 add with carry out and without
    do_op(3'b111, 4'hF, "R7");
    do_op(3'b000, 4'h1, "R2");
    do_op(3'b000, 4'h3, "R2");

    // R3 equality via XNOR
    do_op(3'b111, 4'h6, "R7");
    do_op(3'b001, 4'h6, "R3");
    do_op(3'b111, 4'h6, "R7");
    do_op(3'b001, 4'h7, "R3");

    // R6 decrement corners
    do_op(3'b100, 4'h0, "R6");
    do_op(3'b100, 4'h1, "R6");

    // R4 pass last after a carry
    do_op(3'b111, 4'h8, "R7");
    do_op(3'b000, 4'h8, "R2");
    do_op(3'b010, 4'h5, "R4");

    // R5 logic functions
    do_op(3'b111, 4'hA, "R7");
    do_op(3'b011, 4'h6, "R5");
    do_op(3'b101, 4'h0, "R5");
    do_op(3'b110, 4'h5, "R5");

    // R9 idle holds under every function code
    do_op(3'b111, 4'hF, "R7");
    for (int k = 0; k < 8; k++) idle_cycle(3'(k), 4'(k * 3));

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] f;
      logic [3:0] a;
      f = 3'($urandom);
      a = 4'($urandom);
      if (($urandom % 5) == 0) idle_cycle(f, a);
      else do_op(f, a, tag_of(f));
    end

    // R1 reset in the middle of operation
    do_op(3'b111, 4'hF, "R7");
    do_reset();
    do_op(3'b000, 4'h4, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule